// File: doc/BRIEF.md
# Serial Receiver with Break Wake-Up Monitor

This block is an asynchronous serial receiver for 8N1 frames with a low-power wake-up monitor added. Software arms the monitor by writing a wake-enable bit. While that bit is set, character framing is suspended and the receiver stays idle. The block watches only for the line to drop low. That drop raises the receive interrupt flag and places a dummy byte in the data register. The enable bit stays set until the line returns high, which marks the end of the break. The enable then clears itself and normal reception resumes.

A wake request is produced straight from the raw line while the system is marked as asleep, so a clock controller can be woken without any clock running. In normal operation the interrupt flag is set in step with the system clock. A receive-idle output tells software when no character is in progress, so it can arm the monitor without losing a byte.

Top module: `brkwake_uart_rx`

## Requirements
- R1: While wake-enable reads 1, the receiver stays idle (rxIdle = 1) and no character is framed or loaded, even when the line stays low for many bit times.
- R2: Arming only counts once the synchronized line has been seen high after the enable write. A line that is already low when the enable is written raises no interrupt until it has gone high and then low again.
- R3: While armed, the line going low after having been seen high is a wake event. It sets rxIrq and loads the data register with the dummy value 8'h00.
- R4: The interrupt flag stays set until a one-cycle rdStrobe. The cycle after the read, rxIrq is 0 unless a new event set it in that same cycle.
- R5: After a wake event, the first return of the line to high clears wake-enable by itself within a few cycles. A following good frame is then received normally.
- R6: While sleepIn = 1 and the monitor is armed and ready, wakeReq and rxIrq go high as soon as rxIn goes low, with no clock edge in between. With sleepIn = 0, wakeReq stays 0.
- R7: rxIdle is 1 when no character is in progress and 0 while a frame is being received.
- R8: A frame is a start bit of 0, eight data bits sent LSB first and a stop bit of 1. Each bit lasts OVERSAMPLE*CLKS_PER_TICK clocks (32 by default). Each bit is sampled at its middle. At the stop bit, the byte goes into rxData and rxIrq is set.
- R9: A frame whose stop bit is 0 is discarded. rxData keeps its previous value and rxIrq is not set.
- R10: A second wake event that happens while the flag is still set from an earlier wake leaves the flag set. A single rdStrobe clears it, and it stays clear afterwards.
- R11: After reset, wakeEn = 0, rxIrq = 0, rxData = 8'h00, rxIdle = 1 and wakeReq = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial receive line, idle high |
| sleepIn | input | 1 | System is in its sleep state |
| enWr | input | 1 | Write strobe for the wake-enable bit |
| enWrData | input | 1 | Value written to wake-enable |
| rdStrobe | input | 1 | Read of the receive data register; clears the flag |
| wakeEn | output | 1 | Current wake-enable bit |
| rxIdle | output | 1 | No character reception in progress |
| rxIrq | output | 1 | Receive interrupt flag |
| rxData | output | 8 | Receive data register |
| wakeReq | output | 1 | Asynchronous wake request while asleep |

## Verification
Assertions check the following on every cycle: that an armed receiver is idle, that no wake event fires before the line has been seen high, that the flag holds until a read and drops after one, that a wake event leaves the flag set with dummy data, and that the enable clears on the rising edge after a wake. Only the bench scenarios can show the rest. These are correct LSB-first byte assembly and mid-bit sampling over whole frames, that a frame with a bad stop bit is discarded, that a flag set twice needs only one read, and that the wake request appears combinationally inside one clock period while asleep.

// File: rtl/brkwake_pkg.sv
package brkwake_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;   // capture the current line value into the shifter
    logic loadFrame;  // good stop bit: move shifter to data register
    logic loadDummy;  // wake event: dummy byte into data register
  } dpStrobe_t;

endpackage

// File: rtl/brkwake_dp.sv
module brkwake_dp
  import brkwake_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int CLKS_PER_TICK = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 rdStrobe,
  input  dpStrobe_t            strobe,
  output logic                 rxBit,
  output logic                 rxFall,
  output logic                 tick,
  output logic                 irqFlag,
  output logic [DATA_BITS-1:0] dataReg
);

  logic rxMeta, rxSync, rxPrev;
  logic [DATA_BITS-1:0] shiftReg;

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign rxBit  = rxSync;
  assign rxFall = rxPrev & ~rxSync;

  // oversampling tick generator
  generate
    if (CLKS_PER_TICK == 1) begin : gTickEvery
      assign tick = 1'b1;
    end else begin : gTickDiv
      localparam int PW = $clog2(CLKS_PER_TICK);
      localparam logic [PW-1:0] PLAST = PW'(CLKS_PER_TICK - 1);
      logic [PW-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                preCnt <= '0;
        else if (preCnt == PLAST) preCnt <= '0;
        else                      preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PLAST);
    end
  endgenerate

  // LSB arrives first, so shift in from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      irqFlag <= 1'b0;
    end else if (strobe.loadDummy) begin
      dataReg <= '0;
      irqFlag <= 1'b1;
    end else if (strobe.loadFrame) begin
      dataReg <= shiftReg;
      irqFlag <= 1'b1;
    end else if (rdStrobe) begin
      irqFlag <= 1'b0;
    end
  end

  // R4: flag holds until software reads
  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !rdStrobe |=> irqFlag);

  // R4: a read with no new event clears the flag
  assert_irq_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !strobe.loadFrame && !strobe.loadDummy |=> !irqFlag);

  // R3: a wake event leaves the flag set and dummy data in the register
  assert_dummy_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDummy |=> irqFlag && (dataReg == '0));

endmodule

// File: rtl/brkwake_ctrl.sv
module brkwake_ctrl
  import brkwake_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxBit,
  input  logic      rxFall,
  input  logic      tick,
  input  logic      enWr,
  input  logic      enWrData,
  output dpStrobe_t strobe,
  output logic      wakeEn,
  output logic      armedReady,
  output logic      rxIdle
);

  localparam int SW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OVERSAMPLE - 1);
  localparam logic [SW-1:0] SUB_MID  = SW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

  rxState_t state, nextState;
  logic [SW-1:0] subTick, nextSub;
  logic [BW-1:0] bitIdx, nextIdx;
  logic seenHigh, woke, wakeEvent, armNext;

  // wake monitor
  assign wakeEvent  = wakeEn & seenHigh & ~woke & ~rxBit;
  assign armedReady = seenHigh;
  assign armNext    = wakeEn | (enWr & enWrData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn   <= 1'b0;
      seenHigh <= 1'b0;
      woke     <= 1'b0;
    end else if (enWr) begin
      wakeEn   <= enWrData;
      seenHigh <= 1'b0;
      woke     <= 1'b0;
    end else if (wakeEn) begin
      if (woke && rxBit) begin
        wakeEn   <= 1'b0;
        woke     <= 1'b0;
        seenHigh <= 1'b0;
      end else begin
        if (!seenHigh && rxBit) seenHigh <= 1'b1;
        if (wakeEvent)          woke     <= 1'b1;
      end
    end
  end

  // 8N1 framing
  always_comb begin
    nextState = state;
    nextSub   = subTick;
    nextIdx   = bitIdx;
    strobe    = '0;
    strobe.loadDummy = wakeEvent;
    unique case (state)
      ST_IDLE: begin
        if (rxFall) begin
          nextState = ST_START;
          nextSub   = '0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (subTick == SUB_MID) begin
            nextSub   = '0;
            nextIdx   = '0;
            nextState = rxBit ? ST_IDLE : ST_DATA;
          end else begin
            nextSub = subTick + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (subTick == SUB_LAST) begin
            strobe.shiftBit = 1'b1;
            nextSub = '0;
            if (bitIdx == BIT_LAST) nextState = ST_STOP;
            else                    nextIdx   = bitIdx + 1'b1;
          end else begin
            nextSub = subTick + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (subTick == SUB_LAST) begin
            strobe.loadFrame = rxBit;
            nextState = ST_IDLE;
          end else begin
            nextSub = subTick + 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (armNext) begin
      nextState        = ST_IDLE;
      strobe.shiftBit  = 1'b0;
      strobe.loadFrame = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      subTick <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= nextState;
      subTick <= nextSub;
      bitIdx  <= nextIdx;
    end
  end

  assign rxIdle = (state == ST_IDLE);

  // R1: armed receiver never leaves idle
  assert_armed_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    wakeEn |-> state == ST_IDLE);

  // R2: no wake event before the line has been seen high
  assert_needs_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    wakeEn && !seenHigh |-> !strobe.loadDummy);

  // R5: rising line after a wake clears the enable
  assert_autoclear_R5: assert property (@(posedge clk) disable iff (!rstN)
    wakeEn && woke && rxBit && !enWr |=> !wakeEn);

endmodule

// File: rtl/brkwake_uart_rx.sv
module brkwake_uart_rx
  import brkwake_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int OVERSAMPLE    = 16,
  parameter int CLKS_PER_TICK = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 sleepIn,
  input  logic                 enWr,
  input  logic                 enWrData,
  input  logic                 rdStrobe,
  output logic                 wakeEn,
  output logic                 rxIdle,
  output logic                 rxIrq,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 wakeReq
);

  dpStrobe_t strobe;
  logic rxBit, rxFall, tick, irqFlag, armedReady;

  brkwake_ctrl #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxBit     (rxBit),
    .rxFall    (rxFall),
    .tick      (tick),
    .enWr      (enWr),
    .enWrData  (enWrData),
    .strobe    (strobe),
    .wakeEn    (wakeEn),
    .armedReady(armedReady),
    .rxIdle    (rxIdle)
  );

  brkwake_dp #(
    .DATA_BITS    (DATA_BITS),
    .CLKS_PER_TICK(CLKS_PER_TICK)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .rxIn    (rxIn),
    .rdStrobe(rdStrobe),
    .strobe  (strobe),
    .rxBit   (rxBit),
    .rxFall  (rxFall),
    .tick    (tick),
    .irqFlag (irqFlag),
    .dataReg (rxData)
  );

  // asleep: raw line drives the request with no clock in the path
  assign wakeReq = sleepIn & wakeEn & armedReady & ~rxIn;
  assign rxIrq   = irqFlag | wakeReq;

endmodule

// File: tb/brkwake_uart_rx_test.sv
module brkwake_uart_rx_test;

  localparam int BITCLK = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1, sleepIn = 1'b0, enWr = 1'b0, enWrData = 1'b0, rdStrobe = 1'b0;
  logic wakeEn, rxIdle, rxIrq, wakeReq;
  logic [7:0] rxData;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  logic prevIrq = 1'b0;

  always #4 clk = ~clk;

  brkwake_uart_rx uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sleepIn(sleepIn), .enWr(enWr),
    .enWrData(enWrData), .rdStrobe(rdStrobe), .wakeEn(wakeEn), .rxIdle(rxIdle),
    .rxIrq(rxIrq), .rxData(rxData), .wakeReq(wakeReq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeEn(input logic v);
    @(negedge clk); enWr = 1'b1; enWrData = v;
    @(negedge clk); enWr = 1'b0; enWrData = 1'b0;
  endtask

  task automatic readData();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  // driver: pushes the expected byte for good frames
  task automatic sendFrame(input logic [7:0] b, input logic stopBit);
    if (stopBit) expQ.push_back(b);
    @(negedge clk); rxIn = 1'b0;
    waitClk(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      if (i == 3) begin
        waitClk(2);
        check(rxIdle, 0, "R7 busy mid-frame");
        waitClk(BITCLK - 2);
      end else waitClk(BITCLK);
    end
    rxIn = stopBit;
    waitClk(BITCLK);
    rxIn = 1'b1;
    waitClk(4);
  endtask

  // monitor: compares each newly raised frame flag against the queue
  always @(negedge clk) begin
    if (rstN && rxIrq && !prevIrq && expQ.size() > 0) begin
      logic [7:0] e;
      e = expQ.pop_front();
      check(rxData, e, "R8 frame data");
    end
    prevIrq = rxIrq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    // R11 reset state
    check(wakeEn, 0, "R11 wakeEn");
    check(rxIrq, 0, "R11 rxIrq");
    check(rxData, 8'h00, "R11 rxData");
    check(rxIdle, 1, "R11 rxIdle");
    check(wakeReq, 0, "R11 wakeReq");
    rstN = 1'b1;
    waitClk(4);

    // R8 normal frames
    sendFrame(8'hA5, 1'b1);
    check(rxIrq, 1, "R8 flag at stop");
    check(rxIdle, 1, "R7 idle after frame");
    readData();
    check(rxIrq, 0, "R4 read clears");
    sendFrame(8'h5A, 1'b1);
    readData();
    sendFrame(8'h81, 1'b1);
    readData();

    // R9 framing error
    sendFrame(8'h3C, 1'b0);
    waitClk(BITCLK * 2);
    check(rxIrq, 0, "R9 no flag on bad stop");
    check(rxData, 8'h81, "R9 data kept");

    // R3 / R1 / R5 wake
    writeEn(1'b1);
    waitClk(5);
    check(wakeEn, 1, "R3 armed");
    rxIn = 1'b0;
    waitClk(6);
    check(rxIrq, 1, "R3 wake sets flag");
    check(rxData, 8'h00, "R3 dummy data");
    check(wakeReq, 0, "R6 no request awake");
    check(wakeEn, 1, "R5 enable held while low");
    waitClk(BITCLK * 12);
    check(rxIdle, 1, "R1 idle while armed");
    check(rxData, 8'h00, "R1 no frame loaded");
    rxIn = 1'b1;
    waitClk(6);
    check(wakeEn, 0, "R5 auto-clear");
    check(rxIrq, 1, "R4 flag held");

    // R10 second wake while flag still set
    writeEn(1'b1);
    waitClk(5);
    rxIn = 1'b0;
    waitClk(6);
    check(rxIrq, 1, "R10 flag still set");
    rxIn = 1'b1;
    waitClk(6);
    check(wakeEn, 0, "R10 enable cleared");
    readData();
    check(rxIrq, 0, "R10 single read clears");
    waitClk(10);
    check(rxIrq, 0, "R10 stays clear");

    // R5 normal operation resumes
    sendFrame(8'hC3, 1'b1);
    check(rxData, 8'hC3, "R5 frame after wake");
    readData();

    // R2 arming while line low
    @(negedge clk); rxIn = 1'b0;
    waitClk(2);
    writeEn(1'b1);
    waitClk(20);
    check(rxIrq, 0, "R2 no event while low at arm");
    check(rxIdle, 1, "R1 idle after arm");
    rxIn = 1'b1;
    waitClk(6);
    check(rxIrq, 0, "R2 no event on high");
    rxIn = 1'b0;
    waitClk(6);
    check(rxIrq, 1, "R2 event after seen high");
    rxIn = 1'b1;
    waitClk(6);
    readData();

    // R6 asynchronous request while asleep
    sleepIn = 1'b1;
    writeEn(1'b1);
    waitClk(5);
    @(negedge clk);
    #1 rxIn = 1'b0;
    #1;
    check(wakeReq, 1, "R6 async request");
    check(rxIrq, 1, "R6 async flag");
    waitClk(6);
    rxIn = 1'b1;
    waitClk(6);
    check(wakeReq, 0, "R6 request drops");
    sleepIn = 1'b0;
    readData();
    check(rxIrq, 0, "R4 cleared after sleep wake");
    check(expQ.size(), 0, "R8 all frames seen");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule